// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Flags

This block watches two external pins. For each pin it holds a sticky pending flag that hardware sets when the chosen edge polarity occurs on that pin. Each pending flag drives an interrupt-request output directly. The pins are asynchronous to the core clock, so each one passes through a synchronizer before edge detection.

A single 8-bit special-function register gives software its view of the block. The register holds two pending flags and two edge-select bits. It appears on a combinational read port and takes writes at one decoded address. Software chooses a falling or rising edge for each pin by writing the register. It acknowledges a request by writing 0 to the matching flag bit.

Top module: `ext_irq_edge_flags`

## Requirements
- R1: After reset the register reads 0x00 and both `irq_req` bits are 0.
- R2: `sfr_rdata` shows the register only while `sfr_addr` equals 0xAD, and reads 0x00 at any other address. A write with any other address changes nothing.
- R3: Register layout: bit 7 is the pending flag of `ext_pin[1]` and bit 6 is the pending flag of `ext_pin[0]`. Bit 3 is the edge select of `ext_pin[1]` and bit 2 is the edge select of `ext_pin[0]`. A write loads both select bits.
- R4: An edge-select value of 0 arms a falling edge and a value of 1 arms a rising edge. The other polarity sets no flag.
- R5: A set flag stays set until software clears it. Writing 1 to a flag bit neither sets nor clears it.
- R6: A write with a flag bit at 0 clears that flag. If the selected edge is detected in the same cycle as that clearing write, the flag is left set.
- R7: Bits 5, 4, 1 and 0 always read 0, whatever was written.
- R8: `irq_req[i]` always equals the pending flag of `ext_pin[i]`.
- R9: A pin level first sampled at clock edge k sets its flag at edge k+2. The flag is visible after that edge and not before it.
- R10: Changing an edge-select bit, with no pin transition, sets no flag. The pin levels held through reset set no flag after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write strobe, sampled on the clock |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational from `sfr_addr` |
| ext_pin | input | 2 | Asynchronous external pins |
| irq_req | output | 2 | Interrupt requests, one per pin |

## Verification
The assertions assume that `sfr_addr`, `sfr_wr` and `sfr_wdata` are synchronous to `clk` and stable around each rising edge. They assume `ext_pin` may change at any cycle boundary. The bench drives every input just after the falling edge, so a change is always seen whole by the next rising edge. The random stimulus mostly targets address 0xAD and writes only now and then, so flags can accumulate between clears. It toggles the pins often enough to hit the case where an edge lands in the same cycle as a clearing write.

// File: rtl/ext_irq_edge_flags.sv
module ext_irq_edge_flags #(
  parameter logic [7:0] REG_ADDR    = 8'hAD,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic [1:0] ext_pin,
  output logic [1:0] irq_req
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int WW   = $clog2(WARM + 1);

  logic [WW-1:0] warm;
  logic [1:0]    smp, last, edge_sel, pend, edge_hit;
  logic          warm_done, reg_hit, wr_hit;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], ext_pin[g]};
      assign smp[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  assign warm_done = (warm == WARM[WW-1:0]);
  assign reg_hit   = (sfr_addr == REG_ADDR);
  assign wr_hit    = sfr_wr & reg_hit;
  assign edge_hit  = warm_done ? ((edge_sel & smp & ~last) | (~edge_sel & ~smp & last)) : 2'b00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      warm     <= '0;
      last     <= '0;
      edge_sel <= '0;
      pend     <= '0;
    end else begin
      if (!warm_done) warm <= warm + 1'b1;
      last <= smp;
      if (wr_hit) edge_sel <= sfr_wdata[3:2];
      pend <= edge_hit | (wr_hit ? (pend & sfr_wdata[7:6]) : pend);
    end

  assign sfr_rdata = reg_hit ? {pend, 2'b00, edge_sel, 2'b00} : 8'h00;
  assign irq_req   = pend;
endmodule

module ext_irq_edge_flags_chk #(
  parameter logic [7:0] REG_ADDR = 8'hAD
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sfr_addr,
  input logic       sfr_wr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata,
  input logic [1:0] irq_req,
  input logic [1:0] edge_hit
);
  // R8
  irq_matches_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == REG_ADDR) |-> (irq_req == sfr_rdata[7:6]));
  // R7
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rdata[5:4] == 2'b00) && (sfr_rdata[1:0] == 2'b00));
  // R2
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr != REG_ADDR) |-> (sfr_rdata == 8'h00));
  // R6
  clear_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == REG_ADDR && !sfr_wdata[7] && !edge_hit[1]) |=> !irq_req[1]);
  // R6
  clear_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == REG_ADDR && !sfr_wdata[6] && !edge_hit[0]) |=> !irq_req[0]);
  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != 2'b00) |=> ((irq_req & $past(edge_hit)) == $past(edge_hit)));
  // R5
  sticky_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req[1]) |-> $past(sfr_wr && sfr_addr == REG_ADDR && !sfr_wdata[7]));
  // R5
  sticky_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req[0]) |-> $past(sfr_wr && sfr_addr == REG_ADDR && !sfr_wdata[6]));
endmodule

bind ext_irq_edge_flags ext_irq_edge_flags_chk #(.REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_req(irq_req), .edge_hit(edge_hit)
);

// File: tb/ext_irq_edge_flags_test.sv
module ext_irq_edge_flags_test;
  localparam logic [7:0] A = 8'hAD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = A;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic [1:0] ext_pin = 2'b11;
  logic [1:0] irq_req;

  int checks = 0, fails = 0;
  bit done = 0;

  ext_irq_edge_flags uut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_pin(ext_pin), .irq_req(irq_req)
  );

  always #5 clk = ~clk;

  // reference model: 2-stage capture, 3 edges before edges count
  logic [1:0] q1, q2, q3, m_sel, m_pend;
  int m_warm;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 = 0; q2 = 0; q3 = 0; m_sel = 0; m_pend = 0; m_warm = 0;
    end else begin
      logic [1:0] h;
      h = (m_warm >= 3) ? ((m_sel & q2 & ~q3) | (~m_sel & ~q2 & q3)) : 2'b00;
      if (sfr_wr && sfr_addr == A) begin
        m_pend = h | (m_pend & sfr_wdata[7:6]);
        m_sel  = sfr_wdata[3:2];
      end else m_pend = m_pend | h;
      q3 = q2; q2 = q1; q1 = ext_pin;
      if (m_warm < 3) m_warm++;
    end
  end

  function automatic logic [7:0] exp_read(logic [7:0] addr);
    return (addr == A) ? {m_pend, 2'b00, m_sel, 2'b00} : 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    sfr_wr = 1; sfr_wdata = d; step(1); sfr_wr = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 reset reg", sfr_rdata, 8'h00);
    chk("R1 reset irq", {6'b0, irq_req}, 8'h00);
    rst_n = 1; step(6);
    chk("R10 no flag from pins high at reset", sfr_rdata, 8'h00);
    // falling edge on pin0, default select
    ext_pin[0] = 0; step(2);
    chk("R9 not yet at edge k+1", sfr_rdata, 8'h00);
    step(1);
    chk("R9/R3 fall sets bit6", sfr_rdata, 8'h40);
    chk("R8 irq follows flag", {6'b0, irq_req}, 8'h01);
    wr(8'hC0);
    chk("R5 writing ones leaves flags", sfr_rdata, 8'h40);
    wr(8'h00);
    chk("R6 write zero clears", sfr_rdata, 8'h00);
    wr(8'hFF);
    chk("R7/R5 unused read zero, no sw set", sfr_rdata, 8'h0C);
    ext_pin[0] = 1; step(3);
    chk("R4 rising select sets bit6", sfr_rdata, 8'h4C);
    ext_pin[1] = 0; step(4);
    chk("R4 falling edge ignored on rising select", sfr_rdata, 8'h4C);
    wr(8'h40); step(4);
    chk("R10 select change no spurious", sfr_rdata, 8'h40);
    wr(8'h0C); step(4);
    chk("R10 select change back no spurious", sfr_rdata, 8'h0C);
    sfr_addr = 8'h12; step(1);
    chk("R2 other address reads zero", sfr_rdata, 8'h00);
    wr(8'h00); sfr_addr = A; step(1);
    chk("R2 other address write ignored", sfr_rdata, 8'h0C);
    ext_pin[1] = 1; step(2);
    wr(8'h0C);
    chk("R6 edge beats same-cycle clear", sfr_rdata, 8'h8C);
    chk("R8 irq on pin1", {6'b0, irq_req}, 8'h02);
    wr(8'h0C);
    chk("R6 later clear works", sfr_rdata, 8'h0C);
    ext_pin = 2'b00; rst_n = 0; step(2); rst_n = 1; step(6);
    chk("R10 no flag from pins low at reset", sfr_rdata, 8'h00);
    chk("R1 irq low after reset", {6'b0, irq_req}, 8'h00);
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      step(1);
      chk("R3/R4/R5/R6 random reg", sfr_rdata, exp_read(sfr_addr));
      chk("R8 random irq", {6'b0, irq_req}, {6'b0, m_pend});
      if ($urandom_range(3) == 0) ext_pin = 2'($urandom);
      sfr_addr = ($urandom_range(9) == 0) ? 8'($urandom) : A;
      sfr_wr = ($urandom_range(7) == 0);
      sfr_wdata = 8'($urandom);
    end
    sfr_wr = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule